// File: doc/BRIEF.md
# DRAM Cycle Decoder with Write Mask

This block is the memory-side control of a RAM port. It watches the active-low row strobe, column strobe and write strobe, which arrive already sampled on a fast system clock. It turns them into the commands a small storage array needs: which row to open, when a column is latched, and which bit lanes may be written. Each time the row strobe falls, the block decides what kind of cycle is starting. If the column strobe has been low for long enough, the cycle is an internal refresh, and the row comes from a private counter. Otherwise the cycle is a normal row cycle, and the row comes from the address pins. A normal row cycle may carry any number of fast-page column accesses, or none at all, which makes it a plain row refresh.

The same row-strobe edge samples the write strobe and the data pins. A low write strobe turns on masked writing, and the data pins then become the lane mask. The mask holds for every column write of that row cycle and is dropped when the row strobe rises. Reads load an output data register from the array. An internal refresh started while the column strobe is still held low after a read (a hidden refresh) leaves that register as it was.

Top module: `dram_cycle_top`

## Requirements
- R1: After reset, every strobe output, `actRow`, `colAddr`, `wrEn`, `wrData` and `dataOut` are 0, `cycleKind` is 0 (idle), and the first internal refresh uses row 0.
- R2: A row-strobe fall with the column strobe high gives `rowStrobe`=1 for one cycle, `refreshStrobe`=0, `actRow` equal to `addr`, and `cycleKind`=1 (access). These outputs are registered one clock after the edge at which the fall is first sampled. When the row strobe rises, `cycleKind` returns to 0.
- R3: A row-strobe fall is an internal refresh if the column strobe was sampled low on at least SETUP_CYC (default 2) consecutive clock edges just before it. An internal refresh gives `rowStrobe`=1, `refreshStrobe`=1 and `cycleKind`=2. If the column strobe was low for fewer edges, the cycle is an access as in R2.
- R4: In an internal refresh, `actRow` is the internal counter. The counter goes up by one when the row strobe rises at the end of each internal refresh, and it wraps from 255 to 0. Access cycles leave it unchanged.
- R5: A column-strobe fall during an access cycle gives `colStrobe`=1 for one cycle, with `colAddr` equal to `addr`. A column-strobe fall while the row strobe is high, or during an internal refresh, gives no `colStrobe`.
- R6: If `weN` is low at the row-strobe fall of an access cycle, `dataIn` at that edge is latched as the lane mask. A write (`weN` low at the column fall) then drives `wrEn` equal to that mask, and `wrData` equal to `dataIn`, for one cycle. Bit value 1 enables a lane and bit value 0 blocks it.
- R7: The latched mask stays in force, unchanged, for every column write of the same row cycle, whatever `dataIn` holds at those column edges.
- R8: If `weN` is high at the row-strobe fall, every write in that row cycle drives `wrEn` = all ones.
- R9: A read (`weN` high at the column fall) leaves `wrEn` at 0. One clock after `colStrobe`, `dataOut` is loaded from `rdData`.
- R10: A hidden refresh (the row strobe rises and falls again while the column strobe stays low after a read) is classified as an internal refresh and leaves `dataOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write strobe; it also selects masked writing at the row fall |
| addr | input | 8 | Multiplexed row and column address |
| dataIn | input | 8 | Write data, and the lane mask at the row fall |
| rdData | input | 8 | Read data returned by the array |
| cycleKind | output | 2 | 0 idle, 1 access, 2 internal refresh |
| rowStrobe | output | 1 | One-cycle pulse: open `actRow` |
| refreshStrobe | output | 1 | One-cycle pulse: the row cycle is an internal refresh |
| actRow | output | 8 | Row to activate |
| colStrobe | output | 1 | One-cycle pulse: column latched |
| colAddr | output | 8 | Latched column |
| wrEn | output | 8 | Per-lane write enables, one cycle |
| wrData | output | 8 | Write data for the array |
| dataOut | output | 8 | Output data register |

## Verification
A wrong refresh counter shows up at the very next internal refresh, as a wrong `actRow` one clock after the row fall. The bench therefore runs a full wrap of the counter and checks every refresh row. A stale or mis-latched mask shows up only on a later page write, so bursts of several writes are run with `dataIn` changing between the columns. A setup count that is off by one misclassifies a cycle at the threshold: `refreshStrobe` and `actRow` are wrong in the first cycle after the row fall. Hidden refresh is checked by holding the column strobe low from a read through the next row cycle and comparing `dataOut` against the value read before it.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  parameter int ROW_W  = 8;
  parameter int LANE_W = 8;

  typedef enum logic [1:0] {
    KIND_IDLE    = 2'd0,
    KIND_ACCESS  = 2'd1,
    KIND_REFRESH = 2'd2
  } cycKind_e;

  typedef struct packed {
    logic             rowLatch;
    logic             useCounter;
    logic             colLatch;
    logic             writeGo;
    logic             readGo;
    logic             modeClear;
    logic [ROW_W-1:0] refRow;
  } ctrlStrobe_t;
endpackage

// File: rtl/dram_edge_det.sv
module dram_edge_det #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall,
  output logic rise
);
  logic sigQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sigQ <= RESET_VAL;
    else        sigQ <= sig;
  end

  assign fall = sigQ & ~sig;
  assign rise = ~sigQ & sig;
endmodule

// File: rtl/dram_cyc_ctrl.sv
module dram_cyc_ctrl
  import dram_cyc_pkg::*;
#(
  parameter int SETUP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  output ctrlStrobe_t strobe,
  output cycKind_e    kind
);
  localparam int CNT_W = $clog2(SETUP_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_CYC);

  logic rasFall, rasRise, casFall, casRiseUnused;
  logic [CNT_W-1:0] casLowCnt;
  logic [ROW_W-1:0] refCnt;
  logic cbrNow, colOk;

  dram_edge_det #(.RESET_VAL(1'b1)) rasEdge (
    .clk(clk), .rst_n(rst_n), .sig(rasN), .fall(rasFall), .rise(rasRise)
  );
  dram_edge_det #(.RESET_VAL(1'b1)) casEdge (
    .clk(clk), .rst_n(rst_n), .sig(casN), .fall(casFall), .rise(casRiseUnused)
  );

  // consecutive edges with the column strobe low, saturating at the setup limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    casLowCnt <= '0;
    else if (casN)                 casLowCnt <= '0;
    else if (casLowCnt < SETUP_LIM) casLowCnt <= casLowCnt + 1'b1;
  end

  assign cbrNow = rasFall & (casLowCnt >= SETUP_LIM);
  assign colOk  = casFall & ~rasN & (kind == KIND_ACCESS) & ~casRiseUnused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind   <= KIND_IDLE;
      refCnt <= '0;
    end else if (rasFall) begin
      kind <= cbrNow ? KIND_REFRESH : KIND_ACCESS;
    end else if (rasRise) begin
      kind <= KIND_IDLE;
      if (kind == KIND_REFRESH) refCnt <= refCnt + 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.rowLatch   = rasFall;
    strobe.useCounter = cbrNow;
    strobe.colLatch   = colOk;
    strobe.writeGo    = colOk & ~weN;
    strobe.readGo     = colOk & weN;
    strobe.modeClear  = rasRise;
    strobe.refRow     = refCnt;
  end
endmodule

// File: rtl/dram_cyc_datapath.sv
module dram_cyc_datapath
  import dram_cyc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ROW_W-1:0]  addr,
  input  logic              weN,
  input  logic [LANE_W-1:0] dataIn,
  input  logic [LANE_W-1:0] rdData,
  output logic              rowStrobe,
  output logic              refreshStrobe,
  output logic [ROW_W-1:0]  actRow,
  output logic              colStrobe,
  output logic [ROW_W-1:0]  colAddr,
  output logic [LANE_W-1:0] wrEn,
  output logic [LANE_W-1:0] wrData,
  output logic [LANE_W-1:0] dataOut
);
  logic [LANE_W-1:0] laneMask;
  logic              readPending;

  // row side: activation and the per-cycle lane mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowStrobe     <= 1'b0;
      refreshStrobe <= 1'b0;
      actRow        <= '0;
      laneMask      <= '0;
    end else begin
      rowStrobe     <= strobe.rowLatch;
      refreshStrobe <= strobe.rowLatch & strobe.useCounter;
      if (strobe.rowLatch) begin
        actRow <= strobe.useCounter ? strobe.refRow : addr;
        if (strobe.useCounter) laneMask <= '0;
        else                   laneMask <= weN ? '1 : dataIn;
      end else if (strobe.modeClear) begin
        laneMask <= '0;
      end
    end
  end

  // column side: latch, gated write, read capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colStrobe   <= 1'b0;
      colAddr     <= '0;
      wrEn        <= '0;
      wrData      <= '0;
      dataOut     <= '0;
      readPending <= 1'b0;
    end else begin
      colStrobe   <= strobe.colLatch;
      wrEn        <= strobe.writeGo ? laneMask : '0;
      readPending <= strobe.readGo;
      if (strobe.colLatch) colAddr <= addr;
      if (strobe.writeGo)  wrData  <= dataIn;
      if (readPending)     dataOut <= rdData;
    end
  end
endmodule

// File: rtl/dram_cycle_top.sv
module dram_cycle_top
  import dram_cyc_pkg::*;
#(
  parameter int SETUP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ROW_W-1:0]  addr,
  input  logic [LANE_W-1:0] dataIn,
  input  logic [LANE_W-1:0] rdData,
  output logic [1:0]        cycleKind,
  output logic              rowStrobe,
  output logic              refreshStrobe,
  output logic [ROW_W-1:0]  actRow,
  output logic              colStrobe,
  output logic [ROW_W-1:0]  colAddr,
  output logic [LANE_W-1:0] wrEn,
  output logic [LANE_W-1:0] wrData,
  output logic [LANE_W-1:0] dataOut
);
  ctrlStrobe_t strobe;
  cycKind_e    kind;

  dram_cyc_ctrl #(.SETUP_CYC(SETUP_CYC)) ctrl (
    .clk(clk), .rst_n(rst_n), .rasN(rasN), .casN(casN), .weN(weN),
    .strobe(strobe), .kind(kind)
  );

  dram_cyc_datapath dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .weN(weN),
    .dataIn(dataIn), .rdData(rdData),
    .rowStrobe(rowStrobe), .refreshStrobe(refreshStrobe), .actRow(actRow),
    .colStrobe(colStrobe), .colAddr(colAddr), .wrEn(wrEn), .wrData(wrData),
    .dataOut(dataOut)
  );

  assign cycleKind = kind;
endmodule

// File: rtl/dram_cyc_checker.sv
module dram_cyc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rasN,
  input logic [1:0] cycleKind,
  input logic       rowStrobe,
  input logic       refreshStrobe,
  input logic [7:0] actRow,
  input logic       colStrobe,
  input logic [7:0] wrEn
);
  logic [1:0] kindQ;
  logic [7:0] expRow;

  // independent count of completed internal refreshes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kindQ  <= 2'd0;
      expRow <= 8'd0;
    end else begin
      kindQ <= cycleKind;
      if (kindQ == 2'd2 && cycleKind == 2'd0) expRow <= expRow + 8'd1;
    end
  end

  assert_refresh_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refreshStrobe |-> (rowStrobe && cycleKind == 2'd2));
  assert_row_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rowStrobe |-> $past(cycleKind) == 2'd0);
  assert_refresh_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refreshStrobe |-> actRow == expRow);
  assert_col_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    colStrobe |-> (cycleKind == 2'd1 && !$past(rasN)));
  assert_write_with_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn != 8'd0) |-> colStrobe);
  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cycleKind != 2'd3);
endmodule

bind dram_cycle_top dram_cyc_checker chk (
  .clk(clk), .rst_n(rst_n), .rasN(rasN), .cycleKind(cycleKind),
  .rowStrobe(rowStrobe), .refreshStrobe(refreshStrobe), .actRow(actRow),
  .colStrobe(colStrobe), .wrEn(wrEn)
);

// File: tb/dram_cycle_top_test.sv
module dram_cycle_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [7:0] addr = 8'd0, dataIn = 8'd0;
  logic [7:0] rdData;
  logic [1:0] cycleKind;
  logic rowStrobe, refreshStrobe, colStrobe;
  logic [7:0] actRow, colAddr, wrEn, wrData, dataOut;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expCnt = 8'd0, curMask = 8'd0, lastOut = 8'd0;

  always #4 clk = ~clk;

  function automatic logic [7:0] arrayModel(input logic [7:0] col);
    return (col * 8'd7 + 8'd3) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] laneModel(input bit wpb, input logic [7:0] m);
    return wpb ? m : 8'hFF;
  endfunction

  assign rdData = arrayModel(colAddr);

  dram_cycle_top uut (
    .clk(clk), .rst_n(rst_n), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .rdData(rdData), .cycleKind(cycleKind),
    .rowStrobe(rowStrobe), .refreshStrobe(refreshStrobe), .actRow(actRow),
    .colStrobe(colStrobe), .colAddr(colAddr), .wrEn(wrEn), .wrData(wrData),
    .dataOut(dataOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic openRow(input logic [7:0] row, input bit wpb, input logic [7:0] m);
    rasN = 0; addr = row; weN = !wpb; dataIn = m;
    step();
    chk("R2 rowStrobe", rowStrobe, 1);
    chk("R2 refreshStrobe", refreshStrobe, 0);
    chk("R2 actRow", actRow, row);
    chk("R2 cycleKind", cycleKind, 1);
    curMask = laneModel(wpb, m);
    weN = 1; dataIn = ~m;
    step();
  endtask

  task automatic pageWrite(input logic [7:0] col, input logic [7:0] d);
    casN = 0; addr = col; weN = 0; dataIn = d;
    step();
    chk("R5 colStrobe", colStrobe, 1);
    chk("R5 colAddr", colAddr, col);
    chk("R6 R7 R8 wrEn", wrEn, curMask);
    chk("R6 wrData", wrData, d);
    casN = 1; weN = 1;
    step();
    chk("R6 wrEn one cycle", wrEn, 0);
  endtask

  task automatic pageRead(input logic [7:0] col, input bit keepLow);
    casN = 0; addr = col; weN = 1;
    step();
    chk("R5 colStrobe read", colStrobe, 1);
    chk("R9 no write on read", wrEn, 0);
    step();
    chk("R9 dataOut", dataOut, arrayModel(col));
    lastOut = arrayModel(col);
    if (!keepLow) begin casN = 1; step(); end
  endtask

  task automatic closeRow();
    rasN = 1;
    step();
    chk("R2 kind idle after rise", cycleKind, 0);
    step();
  endtask

  task automatic cbrCycle();
    if (casN) begin casN = 0; step(); end
    step();
    rasN = 0; addr = ~expCnt;
    step();
    chk("R3 refreshStrobe", refreshStrobe, 1);
    chk("R3 rowStrobe", rowStrobe, 1);
    chk("R3 cycleKind", cycleKind, 2);
    chk("R4 actRow counter", actRow, expCnt);
    chk("R10 dataOut kept", dataOut, lastOut);
    rasN = 1;
    step();
    expCnt = expCnt + 8'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 cycleKind", cycleKind, 0);
    chk("R1 strobes", {rowStrobe, refreshStrobe, colStrobe}, 0);
    chk("R1 outputs", {actRow, colAddr, wrEn, wrData, dataOut}, 0);
    cbrCycle(); // R1 first refresh uses row 0
    casN = 1; step();

    // R5: column fall with row strobe high is ignored
    casN = 0; step(); chk("R5 col while row high", colStrobe, 0);
    casN = 1; step();

    // R6 R7: masked burst, dataIn differs at each column
    openRow(8'h3C, 1, 8'b1010_0110);
    pageWrite(8'h01, 8'hFF);
    pageWrite(8'h02, 8'h00);
    pageWrite(8'h03, 8'h5A);
    closeRow();

    // R8: no masking, all lanes
    openRow(8'h44, 0, 8'h00);
    pageWrite(8'h10, 8'h77);
    pageRead(8'h11, 0);
    closeRow();

    // R3: column low for fewer than the setup edges gives an access
    casN = 0; step();
    rasN = 0; addr = 8'h99; step();
    chk("R3 short setup not refresh", refreshStrobe, 0);
    chk("R3 short setup row", actRow, 8'h99);
    chk("R3 short setup kind", cycleKind, 1);
    rasN = 1; casN = 1; step(); step();

    // R10: hidden refresh after a read, then successive refreshes with CAS low
    openRow(8'h21, 0, 8'h00);
    pageRead(8'h42, 1);
    closeRow();
    cbrCycle();
    cbrCycle();
    // R5: column fall during an internal refresh is ignored
    step(); rasN = 0; step();
    casN = 1; step(); casN = 0; step();
    chk("R5 col during refresh", colStrobe, 0);
    rasN = 1; step(); expCnt = expCnt + 8'd1;
    casN = 1; step();

    // random mix
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        cbrCycle();
        casN = 1; step();
      end else begin
        openRow(8'($urandom), bit'($urandom_range(0, 1)), 8'($urandom));
        for (int j = 0; j < int'($urandom_range(1, 4)); j++) begin
          if ($urandom_range(0, 1) == 1) pageWrite(8'($urandom), 8'($urandom));
          else pageRead(8'($urandom), 0);
        end
        closeRow();
      end
    end

    // R4: run the counter through its wrap
    for (int k = 0; k < 260; k++) cbrCycle();
    casN = 1; step();
    cbrCycle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule